// File: doc/BRIEF.md
# Root Port Error Interrupt Generator

This block sits in a PCIe root port and turns incoming error messages into interrupts. Each message carries one of three severities: correctable, non-fatal or fatal. The block records every severity it receives in a root error status register. A root error command register holds one enable per severity. The logical OR over all severities that are both received and enabled is called the combined condition. An interrupt is raised only when the combined condition goes from false to true. A message that lands while the condition is already true only updates status.

Every interrupt goes to exactly one delivery path, picked when it fires. MSI-X is used if it is enabled. MSI is used if MSI-X is off and MSI is on. The legacy INTx level is used if both are off. The MSI and MSI-X outputs are single-cycle pulses that carry the message number held in the status register. The INTx output is a level that stays high until software clears enough status bits for the combined condition to fall.

A control state machine tracks the delivery path that is in force. It has four states:
- `ST_IDLE`: the condition is false and the block is armed.
- `ST_MSIX`: the condition is true and was signalled by MSI-X.
- `ST_MSI`: the condition is true and was signalled by MSI.
- `ST_INTX`: the condition is true and was signalled by INTx.

It has two kinds of transition:
- Arm-to-fire: `ST_IDLE` moves to one of the three active states when the next-cycle condition is true. The target follows the priority above.
- Clear-to-rearm: any active state returns to `ST_IDLE` when the next-cycle condition is false.

Top module: `rperr_irq_gen`

## Requirements
- R1: After reset, the command register, the status bits and the message number all read zero, INTx is low, and no pulse or `msg_sent` is produced.
- R2: An accepted message sets one status bit. Severity code 0 (correctable) sets bit 0, code 1 (non-fatal) sets bit 1 and code 2 (fatal) sets bit 2. Code 3 is ignored and changes no state.
- R3: A message whose severity enable (command bit at the same position as its status bit) is clear produces no notification and leaves `msg_sent` low.
- R4: A message that arrives while the combined condition is already true produces no notification and leaves `msg_sent` low, even if it sets a new enabled bit.
- R5: A false-to-true change of the combined condition produces exactly one notification. `msg_sent` pulses with it only when the change was caused by a message.
- R6: The delivery path is chosen when the interrupt fires, by fixed priority: an MSI-X pulse if `msix_en` is set, else an MSI pulse if `msi_en` is set, else the INTx level. Only one path is used per interrupt.
- R7: `irq_vec` on an MSI or MSI-X pulse equals the message number field, which sits at status bits [31:27] and is written through status writes.
- R8: Status bits [2:0] are write-1-to-clear. When clearing makes the combined condition false, INTx drops and the next false-to-true change fires again.
- R9: Setting a command enable while its status bit is already set, with the condition previously false, fires one interrupt with `msg_sent` low.
- R10: When a message and a write-1-to-clear of the same status bit happen in the same cycle, the bit ends up set.
- R11: All notification outputs change in the cycle after the accepting clock edge. An MSI or MSI-X pulse lasts one cycle, and INTx holds while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | One error message this cycle |
| msg_sev | input | 2 | Message severity code (0 correctable, 1 non-fatal, 2 fatal, 3 ignored) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 command, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 command, 1 status |
| rd_data | output | 32 | Read data for `rd_addr` |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| msix_pulse | output | 1 | One-cycle MSI-X notification |
| msi_pulse | output | 1 | One-cycle MSI notification |
| irq_vec | output | 5 | Message number carried with a pulse |
| intx_level | output | 1 | Legacy interrupt level |
| msg_sent | output | 1 | The notification in this cycle was caused by a message |

## Verification
The bench targets the suppression cases. A fatal message that arrives while a non-fatal one is already pending must stay silent. A design that triggers on each newly set bit would send a second MSI there. It also checks that a message whose enable is clear changes only status, and that a reserved severity code changes nothing.

The bench checks that enabling a command bit over an already-set status bit fires once with `msg_sent` low. A design that decides only when a message arrives would miss this. It checks that a message and a write-1-to-clear of the same bit in one cycle leave the bit set and raise INTx. A design that lets the clear win would lose that interrupt. Finally, it clears INTx and raises it again to show the block re-arms, and it changes `msix_en` and `msi_en` between interrupts to test the delivery priority.

// File: rtl/rperr_pkg.sv
package rperr_pkg;

    localparam int NSEV = 3;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_RSVD     = 2'd3
    } sev_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSIX = 2'd1,
        ST_MSI  = 2'd2,
        ST_INTX = 2'd3
    } notify_st_e;

    typedef enum logic {
        ADDR_CMD  = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    // One-hot status set vector for an accepted message; reserved code gives zero.
    function automatic logic [NSEV-1:0] sev_onehot(input logic valid, input logic [1:0] sev);
        logic [NSEV-1:0] v;
        v = '0;
        for (int i = 0; i < NSEV; i++) begin
            if (valid && (sev == 2'(i))) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/rperr_regs.sv
module rperr_regs
    import rperr_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic [NSEV-1:0]  status_q,
    output logic [NSEV-1:0]  cmd_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             cond_now,
    output logic             cond_next,
    output logic             msg_hit_next
);

    localparam int VEC_LSB = REG_W - VEC_W;

    logic [NSEV-1:0]  set_vec;
    logic [NSEV-1:0]  status_d;
    logic [NSEV-1:0]  cmd_d;
    logic [VEC_W-1:0] vec_d;
    logic             wr_stat;
    logic             wr_cmd;
    logic             unused_wr_bits;

    assign set_vec        = sev_onehot(msg_valid, msg_sev);
    assign wr_stat        = wr_en && (wr_addr == ADDR_STAT);
    assign wr_cmd         = wr_en && (wr_addr == ADDR_CMD);
    assign unused_wr_bits = ^wr_data[VEC_LSB-1:NSEV];

    // Per-severity next state: a message set wins over a same-cycle clear.
    for (genvar i = 0; i < NSEV; i++) begin : g_sev
        assign status_d[i] = set_vec[i] | (status_q[i] & ~(wr_stat & wr_data[i]));
        assign cmd_d[i]    = wr_cmd ? wr_data[i] : cmd_q[i];
    end

    assign vec_d = wr_stat ? wr_data[VEC_LSB +: VEC_W] : vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            cmd_q    <= '0;
            vec_q    <= '0;
        end else begin
            status_q <= status_d;
            cmd_q    <= cmd_d;
            vec_q    <= vec_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_STAT) begin
            rd_data[NSEV-1:0]         = status_q;
            rd_data[VEC_LSB +: VEC_W] = vec_q;
        end else begin
            rd_data[NSEV-1:0] = cmd_q;
        end
    end

    assign cond_now     = |(status_q & cmd_q);
    assign cond_next    = |(status_d & cmd_d);
    assign msg_hit_next = |(set_vec & cmd_d);

    // R2 / R10: an accepted message leaves its status bit set, clear or not
    p_sev_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev != SEV_RSVD) |=> status_q[$past(msg_sev)]);

    // R2: the reserved code alone changes no status
    p_rsvd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev == SEV_RSVD && !wr_en) |=> status_q == $past(status_q));

    // R8: written ones clear status bits when no message competes
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_STAT && !msg_valid) |=> ((status_q & $past(wr_data[NSEV-1:0])) == '0));

endmodule

// File: rtl/rperr_notify_fsm.sv
module rperr_notify_fsm
    import rperr_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_now,
    input  logic             cond_next,
    input  logic             msg_hit_next,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec_q,
    output logic             msix_pulse,
    output logic             msi_pulse,
    output logic [VEC_W-1:0] irq_vec,
    output logic             intx_level,
    output logic             msg_sent
);

    notify_st_e state_q;
    notify_st_e state_d;
    logic       fire;

    // Next state: arm-to-fire from idle, clear-to-rearm from any active state.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cond_next) begin
                    fire = 1'b1;
                    if (msix_en)     state_d = ST_MSIX;
                    else if (msi_en) state_d = ST_MSI;
                    else             state_d = ST_INTX;
                end
            end
            ST_MSIX, ST_MSI, ST_INTX: begin
                if (!cond_next) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msix_pulse <= 1'b0;
            msi_pulse  <= 1'b0;
            irq_vec    <= '0;
            msg_sent   <= 1'b0;
        end else begin
            msix_pulse <= fire && (state_d == ST_MSIX);
            msi_pulse  <= fire && (state_d == ST_MSI);
            irq_vec    <= (fire && state_d != ST_INTX) ? vec_q : '0;
            msg_sent   <= fire && msg_hit_next;
        end
    end

    assign intx_level = (state_q == ST_INTX);

    // R4: the state machine is active exactly while the registered condition holds
    p_state_tracks_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) == cond_now);

    // R5: msg_sent never appears without a notification
    p_sent_with_notify_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_sent |-> (msix_pulse || msi_pulse || $rose(intx_level)));

    // R6: one delivery path at a time
    p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msix_pulse, msi_pulse, intx_level}));

    // R6: MSI is used only when MSI-X was off at the firing edge
    p_msix_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> !$past(msix_en));

    // R11: pulses last a single cycle
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (msix_pulse || msi_pulse) |=> !(msix_pulse || msi_pulse));

    // R8: INTx only while the condition holds
    p_intx_needs_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intx_level |-> cond_now);

endmodule

// File: rtl/rperr_irq_gen.sv
module rperr_irq_gen
    import rperr_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             msix_en,
    input  logic             msi_en,
    output logic             msix_pulse,
    output logic             msi_pulse,
    output logic [VEC_W-1:0] irq_vec,
    output logic             intx_level,
    output logic             msg_sent
);

    logic [NSEV-1:0]  status_q;
    logic [NSEV-1:0]  cmd_q;
    logic [VEC_W-1:0] vec_q;
    logic             cond_now;
    logic             cond_next;
    logic             msg_hit_next;

    rperr_regs #(.REG_W(REG_W), .VEC_W(VEC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .msg_valid    (msg_valid),
        .msg_sev      (msg_sev),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .status_q     (status_q),
        .cmd_q        (cmd_q),
        .vec_q        (vec_q),
        .cond_now     (cond_now),
        .cond_next    (cond_next),
        .msg_hit_next (msg_hit_next)
    );

    rperr_notify_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_now     (cond_now),
        .cond_next    (cond_next),
        .msg_hit_next (msg_hit_next),
        .msix_en      (msix_en),
        .msi_en       (msi_en),
        .vec_q        (vec_q),
        .msix_pulse   (msix_pulse),
        .msi_pulse    (msi_pulse),
        .irq_vec      (irq_vec),
        .intx_level   (intx_level),
        .msg_sent     (msg_sent)
    );

    // R3: a message with its enable clear (and no command write) is never reported sent
    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_sev != SEV_RSVD && !wr_en && !cmd_q[msg_sev]) |=> !msg_sent);

endmodule

// File: tb/rperr_irq_gen_tb_top.sv
`timescale 1ns/1ps
module rperr_irq_gen_tb_top;

    localparam logic [31:0] V = 32'h4800_0000;  // message number 9 at bits [31:27]

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        msix_en = 1'b0;
    logic        msi_en = 1'b0;
    logic        msix_pulse, msi_pulse, intx_level, msg_sent;
    logic [4:0]  irq_vec;

    always #10 clk = ~clk;

    rperr_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .msix_en(msix_en), .msi_en(msi_en),
        .msix_pulse(msix_pulse), .msi_pulse(msi_pulse), .irq_vec(irq_vec),
        .intx_level(intx_level), .msg_sent(msg_sent)
    );

    typedef struct {
        int         kind;   // 0 MSI-X, 1 MSI, 2 INTx
        logic [4:0] vec;
        logic       sent;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic intx_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [4:0] vec, input logic sent, input string req);
        exp_t e;
        e.kind = kind; e.vec = vec; e.sent = sent; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: each observed notification is matched against the scoreboard queue.
    always @(negedge clk) begin : mon
        int   kind;
        exp_t e;
        if (rst_n) begin
            if (msix_pulse || msi_pulse || (intx_level && !intx_prev)) begin
                kind = msix_pulse ? 0 : (msi_pulse ? 1 : 2);
                if (q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected notification kind", kind, 32'hFF);
                end else begin
                    e = q.pop_front();
                    chk(e.kind == kind, e.req, "notification kind", kind, e.kind);
                    if (kind != 2) chk(irq_vec == e.vec, "R7", "vector", irq_vec, e.vec);
                    chk(msg_sent == e.sent, e.req, "msg_sent", msg_sent, e.sent);
                end
            end else if (msg_sent) begin
                chk(1'b0, "R5", "msg_sent without notification", 1, 0);
            end
        end
        intx_prev = intx_level;
    end

    // Drives one cycle of stimulus starting just after a falling edge.
    task automatic cyc(input logic mv, input logic [1:0] sev, input logic we,
                       input logic wa, input logic [31:0] wd);
        msg_valid = mv; msg_sev = sev; wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        msg_valid = 1'b0; msg_sev = 2'd0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    endtask

    task automatic quiet(input string req);
        chk(!msix_pulse && !msi_pulse && !msg_sent, req, "no notification",
            {29'd0, msix_pulse, msi_pulse, msg_sent}, 0);
    endtask

    task automatic rd(input logic a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, a ? "status read" : "command read", rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, 32'h0, "R1");
        rd(1'b1, 32'h0, "R1");
        chk(!intx_level, "R1", "intx after reset", intx_level, 0);
        quiet("R1");

        // Setup: all enables, message number 9, MSI delivery
        cyc(0, 0, 1, 1'b0, 32'h7);
        cyc(0, 0, 1, 1'b1, V);
        rd(1'b1, V, "R7");
        msi_en = 1'b1;

        // R6/R5: non-fatal fires MSI
        expect_ev(1, 5'd9, 1'b1, "R6");
        cyc(1, 2'd1, 0, 1'b0, 0);
        rd(1'b1, V | 32'h2, "R2");
        cyc(0, 0, 0, 1'b0, 0);
        quiet("R11");

        // R4: fatal while condition already true stays silent
        cyc(1, 2'd2, 0, 1'b0, 0);
        quiet("R4");
        rd(1'b1, V | 32'h6, "R2");

        // R8: clear both bits, vector kept
        cyc(0, 0, 1, 1'b1, V | 32'h6);
        rd(1'b1, V, "R8");

        // R6: MSI-X takes priority
        msix_en = 1'b1;
        expect_ev(0, 5'd9, 1'b1, "R6");
        cyc(1, 2'd0, 0, 1'b0, 0);

        // R3: disabled severity records but stays silent
        cyc(0, 0, 1, 1'b1, V | 32'h1);
        cyc(0, 0, 1, 1'b0, 32'h4);
        cyc(1, 2'd0, 0, 1'b0, 0);
        quiet("R3");
        rd(1'b1, V | 32'h1, "R3");

        // R2: reserved code ignored
        cyc(1, 2'd3, 0, 1'b0, 0);
        quiet("R2");
        rd(1'b1, V | 32'h1, "R2");

        // R9: enabling over a set status bit fires once, not a message
        expect_ev(0, 5'd9, 1'b0, "R9");
        cyc(0, 0, 1, 1'b0, 32'h5);
        rd(1'b0, 32'h5, "R9");

        // R6: INTx when both message paths are off
        cyc(0, 0, 1, 1'b1, V | 32'h1);
        msix_en = 1'b0; msi_en = 1'b0;
        expect_ev(2, 5'd0, 1'b1, "R6");
        cyc(1, 2'd2, 0, 1'b0, 0);
        chk(intx_level, "R6", "intx raised", intx_level, 1);
        cyc(0, 0, 0, 1'b0, 0);
        chk(intx_level, "R11", "intx held", intx_level, 1);
        cyc(1, 2'd2, 0, 1'b0, 0);
        quiet("R4");
        chk(intx_level, "R4", "intx still held", intx_level, 1);

        // R8: clear drops INTx
        cyc(0, 0, 1, 1'b1, V | 32'h4);
        chk(!intx_level, "R8", "intx dropped", intx_level, 0);

        // R10: message beats same-cycle clear
        expect_ev(2, 5'd0, 1'b1, "R10");
        cyc(1, 2'd2, 1, 1'b1, V | 32'h4);
        rd(1'b1, V | 32'h4, "R10");
        chk(intx_level, "R10", "intx after race", intx_level, 1);
        cyc(0, 0, 1, 1'b1, V | 32'h4);
        chk(!intx_level, "R8", "intx dropped again", intx_level, 0);

        // R8: re-armed
        expect_ev(2, 5'd0, 1'b1, "R8");
        cyc(1, 2'd2, 0, 1'b0, 0);
        chk(intx_level, "R8", "intx re-raised", intx_level, 1);

        cyc(0, 0, 0, 1'b0, 0);
        chk(q.size() == 0, "R5", "pending expectations", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule